// File: doc/BRIEF.md
# Tree Pattern Matcher with Binding Store

This block decides whether a pattern term fits a target term and, when it does, reports which subterm each pattern variable stands for. Both terms live in an external term store that is hash-consed: identical subterms always share one id. The matcher reads nodes through two combinational read ports, one for the pattern walk and one for the target walk. It visits the two trees in lockstep, depth first and left to right, one node pair per clock, and stops at the first disagreement.

Pattern variables are recorded in a small content-addressed binding table. The first time a variable is seen, it captures the id of the target subterm at the same position. When the same variable is seen again, the id at that position must equal the captured id, otherwise the match fails at once. Children are compared in order. No commutative or associative reordering is done, and variables inside the target are plain nodes. After a successful match the bindings are drained in first-occurrence order from a FIFO-style read port that carries a level count.

A pending-pair stack bounds how deep the walk may go. Running out of binding slots and running out of stack each end the operation with an error code of their own, separate from an ordinary mismatch.

Top module: `tree_pattern_matcher`

## Requirements
- R1: After reset, `busy`, `done` and `bind_level` are all 0 and `bind_valid` is low.
- R2: Node word layout is {child[1] id, child[0] id, symbol, arity, tag}, with tag in bits [1:0] and arity in [3:2] at the default widths. Tag codes are 0 constant, 1 function, 2 variable. A non-variable pattern node matches only when tag, arity and symbol all equal those of the target node. Children are compared position by position, so f(a,b) does not match f(b,a).
- R3: A pattern variable with no capture binds to the id of the target subterm at its position, whether that subterm is a leaf or not. f(X) against f(a) matches with binding X = id(a).
- R4: A variable met again must sit opposite a target id equal to its capture. f(X,X) matches f(a,a) with one binding and fails on f(a,b).
- R5: `result` codes are 0 match, 1 fail, 2 binding overflow, 3 depth error. `done` is a one-cycle pulse, and `result` holds until the next accepted start. A successful match of an N-node pattern raises `done` after the (N+2)th rising edge, counting the edge that samples `start` as the first. A mismatch ends the walk on the edge that examines the failing pair, so a root mismatch raises `done` after the 2nd edge.
- R6: After a match, `bind_level` equals the number of distinct variables. `bind_data` = {variable symbol, subterm id} presents bindings in order of first occurrence, and each `bind_pop` while `bind_valid` is high advances to the next binding and lowers the level by one.
- R7: Every accepted start clears the binding table, so no binding from an earlier match appears in a later one.
- R8: With 16 slots, a pattern of 16 distinct variables matches. A seventeenth distinct variable ends the operation with result 2, not 1.
- R9: The stack holds 16 pending pairs. Expanding a node whose children would push the count past 16 ends the operation with result 3. A left-nested chain of 15 binary nodes matches, and a chain of 16 gives result 3.
- R10: When the result is not 0, `bind_level` is 0 and `bind_valid` is low.
- R11: `start` is ignored while `busy` is high, and the running operation finishes with its own roots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a match when idle |
| pat_root | input | ID_W | Pattern root id |
| tgt_root | input | ID_W | Target root id |
| pat_rd_id | output | ID_W | Term store read address, pattern side |
| pat_rd_node | input | NODE_W | Node word at `pat_rd_id` (same cycle) |
| tgt_rd_id | output | ID_W | Term store read address, target side |
| tgt_rd_node | input | NODE_W | Node word at `tgt_rd_id` (same cycle) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Outcome code |
| bind_pop | input | 1 | Advance the binding read port |
| bind_valid | output | 1 | A binding is available |
| bind_data | output | SYM_W+ID_W | {variable symbol, subterm id} |
| bind_level | output | LVL_W | Bindings left to read |

## Verification
The hardest outcomes to reach from the ports are the two error exits. Each needs a term whose shape drives internal occupancy to an exact limit. For binding overflow, the bench builds right-nested binary chains carrying 16 and then 17 distinct variables, which keeps stack use at two entries while the slot count climbs. For the depth error, it builds left-nested binary chains of 15 and 16 levels, where every level leaves one right sibling pending. The same term is used as both pattern and target, so the only possible outcome apart from success is the depth error.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
   typedef enum logic [1:0] {
      TAG_CONST = 2'd0,
      TAG_FUNC  = 2'd1,
      TAG_VAR   = 2'd2,
      TAG_RSVD  = 2'd3
   } tag_e;

   typedef enum logic [1:0] {
      RES_MATCH    = 2'd0,
      RES_FAIL     = 2'd1,
      RES_OVERFLOW = 2'd2,
      RES_DEPTH    = 2'd3
   } res_e;
endpackage

// File: rtl/tpm_node_cmp.sv
module tpm_node_cmp #(
   parameter int ID_W      = 8,
   parameter int SYM_W     = 8,
   parameter int MAX_ARITY = 2,
   localparam int ARW      = $clog2(MAX_ARITY + 1),
   localparam int NODE_W   = 2 + ARW + SYM_W + MAX_ARITY * ID_W
) (
   input  logic [NODE_W-1:0]          pat_node,
   input  logic [NODE_W-1:0]          tgt_node,
   output logic                       pat_is_var,
   output logic [SYM_W-1:0]           pat_sym,
   output logic [ARW-1:0]             pat_arity,
   output logic                       shape_eq,
   output logic [MAX_ARITY*ID_W-1:0]  pat_kids,
   output logic [MAX_ARITY*ID_W-1:0]  tgt_kids
);
   import tpm_pkg::*;

   localparam int SYM_LSB = 2 + ARW;
   localparam int KID_LSB = SYM_LSB + SYM_W;

   logic [1:0]       p_tag, t_tag;
   logic [ARW-1:0]   t_arity;
   logic [SYM_W-1:0] t_sym;

   assign p_tag     = pat_node[1:0];
   assign t_tag     = tgt_node[1:0];
   assign pat_arity = pat_node[2 +: ARW];
   assign t_arity   = tgt_node[2 +: ARW];
   assign pat_sym   = pat_node[SYM_LSB +: SYM_W];
   assign t_sym     = tgt_node[SYM_LSB +: SYM_W];
   assign pat_kids  = pat_node[KID_LSB +: MAX_ARITY*ID_W];
   assign tgt_kids  = tgt_node[KID_LSB +: MAX_ARITY*ID_W];

   assign pat_is_var = (p_tag == TAG_VAR);
   assign shape_eq   = (p_tag == t_tag) && (pat_arity == t_arity) &&
                       (pat_sym == t_sym) && (pat_arity <= ARW'(MAX_ARITY));
endmodule

// File: rtl/tpm_walk_stack.sv
module tpm_walk_stack #(
   parameter int ID_W      = 8,
   parameter int MAX_ARITY = 2,
   parameter int DEPTH     = 16,
   localparam int ARW      = $clog2(MAX_ARITY + 1),
   localparam int SPW      = $clog2(DEPTH + 1),
   localparam int IXW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [ID_W-1:0]            load_pat,
   input  logic [ID_W-1:0]            load_tgt,
   input  logic                       step,
   input  logic [ARW-1:0]             push_n,
   input  logic [MAX_ARITY*ID_W-1:0]  kids_pat,
   input  logic [MAX_ARITY*ID_W-1:0]  kids_tgt,
   output logic [ID_W-1:0]            top_pat,
   output logic [ID_W-1:0]            top_tgt,
   output logic [SPW-1:0]             sp,
   output logic                       empty
);
   logic [ID_W-1:0] pat_q [DEPTH];
   logic [ID_W-1:0] tgt_q [DEPTH];

   assign top_pat = pat_q[IXW'(sp - SPW'(1))];
   assign top_tgt = tgt_q[IXW'(sp - SPW'(1))];
   assign empty   = (sp == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= '0;
      end else if (load) begin
         sp <= SPW'(1);
      end else if (step) begin
         sp <= sp - SPW'(1) + SPW'(push_n);
      end
   end

   // Children are written in reverse so that child 0 ends on top.
   always_ff @(posedge clk) begin
      if (load) begin
         pat_q[0] <= load_pat;
         tgt_q[0] <= load_tgt;
      end else if (step) begin
         for (int i = 0; i < MAX_ARITY; i++) begin
            if (i < int'(push_n)) begin
               pat_q[IXW'(int'(sp) + int'(push_n) - 2 - i)] <= kids_pat[i*ID_W +: ID_W];
               tgt_q[IXW'(int'(sp) + int'(push_n) - 2 - i)] <= kids_tgt[i*ID_W +: ID_W];
            end
         end
      end
   end
endmodule

// File: rtl/tpm_bind_cam.sv
module tpm_bind_cam #(
   parameter int ID_W   = 8,
   parameter int SYM_W  = 8,
   parameter int SLOTS  = 16,
   localparam int CW    = $clog2(SLOTS + 1),
   localparam int IXW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic [SYM_W-1:0]       look_sym,
   input  logic                   ins,
   input  logic [ID_W-1:0]        ins_id,
   output logic                   hit,
   output logic [ID_W-1:0]        hit_id,
   output logic [SLOTS-1:0]       hit_vec,
   output logic                   full,
   output logic [CW-1:0]          count,
   input  logic                   rd_pop,
   output logic [CW-1:0]          rd_ptr,
   output logic [SYM_W+ID_W-1:0]  rd_data
);
   logic [SYM_W-1:0] sym_q [SLOTS];
   logic [ID_W-1:0]  id_q  [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign hit_vec[s] = (CW'(s) < count) && (sym_q[s] == look_sym);
   end

   always_comb begin
      hit_id = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (hit_vec[s]) hit_id = hit_id | id_q[s];
      end
   end

   assign hit     = |hit_vec;
   assign full    = (count == CW'(SLOTS));
   assign rd_data = {sym_q[IXW'(rd_ptr)], id_q[IXW'(rd_ptr)]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         rd_ptr <= '0;
      end else if (clear) begin
         count  <= '0;
         rd_ptr <= '0;
      end else begin
         if (ins && !full) count <= count + CW'(1);
         if (rd_pop)       rd_ptr <= rd_ptr + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (ins && !full && !clear) begin
         sym_q[IXW'(count)] <= look_sym;
         id_q[IXW'(count)]  <= ins_id;
      end
   end
endmodule

// File: rtl/tree_pattern_matcher.sv
module tree_pattern_matcher #(
   parameter int ID_W        = 8,
   parameter int SYM_W       = 8,
   parameter int MAX_ARITY   = 2,
   parameter int CAM_SLOTS   = 16,
   parameter int STACK_DEPTH = 16,
   localparam int ARW        = $clog2(MAX_ARITY + 1),
   localparam int NODE_W     = 2 + ARW + SYM_W + MAX_ARITY * ID_W,
   localparam int LVL_W      = $clog2(CAM_SLOTS + 1),
   localparam int SPW        = $clog2(STACK_DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [ID_W-1:0]        pat_root,
   input  logic [ID_W-1:0]        tgt_root,
   output logic [ID_W-1:0]        pat_rd_id,
   input  logic [NODE_W-1:0]      pat_rd_node,
   output logic [ID_W-1:0]        tgt_rd_id,
   input  logic [NODE_W-1:0]      tgt_rd_node,
   output logic                   busy,
   output logic                   done,
   output logic [1:0]             result,
   input  logic                   bind_pop,
   output logic                   bind_valid,
   output logic [SYM_W+ID_W-1:0]  bind_data,
   output logic [LVL_W-1:0]       bind_level
);
   import tpm_pkg::*;

   if (CAM_SLOTS < 1) begin : g_bad_slots
      $error("CAM_SLOTS must be at least 1");
   end
   if (MAX_ARITY < 1) begin : g_bad_arity
      $error("MAX_ARITY must be at least 1");
   end
   if (STACK_DEPTH < MAX_ARITY) begin : g_bad_depth
      $error("STACK_DEPTH must be at least MAX_ARITY");
   end

   logic                      busy_q, done_q;
   res_e                      result_q;
   logic                      pat_is_var, shape_eq;
   logic [SYM_W-1:0]          pat_sym;
   logic [ARW-1:0]            pat_arity;
   logic [MAX_ARITY*ID_W-1:0] pat_kids, tgt_kids;
   logic                      accept, stk_step, cam_ins, fin, depth_over;
   res_e                      fin_code;
   logic [ID_W-1:0]           stk_top_pat, stk_top_tgt;
   logic [SPW-1:0]            stk_sp;
   logic                      stk_empty;
   logic                      cam_hit, cam_full;
   logic [ID_W-1:0]           cam_hit_id;
   logic [CAM_SLOTS-1:0]      cam_hit_vec;
   logic [LVL_W-1:0]          cam_count, cam_rd_ptr;
   logic [ARW-1:0]            push_n;

   assign accept = start && !busy_q;

   tpm_node_cmp #(.ID_W(ID_W), .SYM_W(SYM_W), .MAX_ARITY(MAX_ARITY)) u_cmp (
      .pat_node   (pat_rd_node),
      .tgt_node   (tgt_rd_node),
      .pat_is_var (pat_is_var),
      .pat_sym    (pat_sym),
      .pat_arity  (pat_arity),
      .shape_eq   (shape_eq),
      .pat_kids   (pat_kids),
      .tgt_kids   (tgt_kids)
   );

   assign push_n = pat_is_var ? '0 : pat_arity;

   tpm_walk_stack #(.ID_W(ID_W), .MAX_ARITY(MAX_ARITY), .DEPTH(STACK_DEPTH)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_pat (pat_root),
      .load_tgt (tgt_root),
      .step     (stk_step),
      .push_n   (push_n),
      .kids_pat (pat_kids),
      .kids_tgt (tgt_kids),
      .top_pat  (stk_top_pat),
      .top_tgt  (stk_top_tgt),
      .sp       (stk_sp),
      .empty    (stk_empty)
   );

   tpm_bind_cam #(.ID_W(ID_W), .SYM_W(SYM_W), .SLOTS(CAM_SLOTS)) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .look_sym (pat_sym),
      .ins      (cam_ins),
      .ins_id   (stk_top_tgt),
      .hit      (cam_hit),
      .hit_id   (cam_hit_id),
      .hit_vec  (cam_hit_vec),
      .full     (cam_full),
      .count    (cam_count),
      .rd_pop   (bind_pop && bind_valid),
      .rd_ptr   (cam_rd_ptr),
      .rd_data  (bind_data)
   );

   assign pat_rd_id  = stk_top_pat;
   assign tgt_rd_id  = stk_top_tgt;
   assign depth_over = (int'(stk_sp) + int'(pat_arity) - 1) > STACK_DEPTH;

   always_comb begin
      fin      = 1'b0;
      fin_code = RES_MATCH;
      stk_step = 1'b0;
      cam_ins  = 1'b0;
      if (busy_q) begin
         if (stk_empty) begin
            fin = 1'b1;
         end else if (pat_is_var) begin
            if (cam_hit) begin
               if (cam_hit_id != stk_top_tgt) begin
                  fin      = 1'b1;
                  fin_code = RES_FAIL;
               end else begin
                  stk_step = 1'b1;
               end
            end else if (cam_full) begin
               fin      = 1'b1;
               fin_code = RES_OVERFLOW;
            end else begin
               cam_ins  = 1'b1;
               stk_step = 1'b1;
            end
         end else if (!shape_eq) begin
            fin      = 1'b1;
            fin_code = RES_FAIL;
         end else if (depth_over) begin
            fin      = 1'b1;
            fin_code = RES_DEPTH;
         end else begin
            stk_step = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         result_q <= RES_MATCH;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
         end else if (fin) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            result_q <= fin_code;
         end
      end
   end

   assign busy       = busy_q;
   assign done       = done_q;
   assign result     = result_q;
   assign bind_level = (!busy_q && result_q == RES_MATCH) ? (cam_count - cam_rd_ptr) : '0;
   assign bind_valid = (bind_level != '0);
endmodule

// File: rtl/tpm_matcher_chk.sv
module tpm_matcher_chk #(
   parameter int CAM_SLOTS   = 16,
   parameter int STACK_DEPTH = 16,
   parameter int LVL_W       = 5,
   parameter int SPW         = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 busy,
   input logic                 done,
   input logic [1:0]           result,
   input logic [LVL_W-1:0]     bind_level,
   input logic                 bind_valid,
   input logic [CAM_SLOTS-1:0] cam_hit_vec,
   input logic [SPW-1:0]       stk_sp
);
   import tpm_pkg::*;

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bind_level <= LVL_W'(CAM_SLOTS));

   p_unique_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cam_hit_vec));

   p_stack_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(stk_sp) <= STACK_DEPTH);

   p_empty_on_error_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (result != RES_MATCH) |-> (bind_level == '0 && !bind_valid));

   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> (busy || done));
endmodule

bind tree_pattern_matcher tpm_matcher_chk #(
   .CAM_SLOTS   (CAM_SLOTS),
   .STACK_DEPTH (STACK_DEPTH),
   .LVL_W       (LVL_W),
   .SPW         (SPW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .result      (result),
   .bind_level  (bind_level),
   .bind_valid  (bind_valid),
   .cam_hit_vec (cam_hit_vec),
   .stk_sp      (stk_sp)
);

// File: tb/tb_tree_pattern_matcher.sv
module tb_tree_pattern_matcher;
   localparam int ID_W = 8, SYM_W = 8, MAX_ARITY = 2;
   localparam int NODE_W = 2 + 2 + SYM_W + MAX_ARITY * ID_W;
   localparam int LVL_W = 5;
   localparam int C_TAG = 0, F_TAG = 1, V_TAG = 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bind_pop = 1'b0;
   logic [ID_W-1:0] pat_root = '0, tgt_root = '0, pat_rd_id, tgt_rd_id;
   logic [NODE_W-1:0] pat_rd_node, tgt_rd_node;
   logic busy, done, bind_valid;
   logic [1:0] result;
   logic [SYM_W+ID_W-1:0] bind_data;
   logic [LVL_W-1:0] bind_level;

   logic [NODE_W-1:0] mem [256];
   int nxt = 1;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   assign pat_rd_node = mem[pat_rd_id];
   assign tgt_rd_node = mem[tgt_rd_id];

   tree_pattern_matcher dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pat_root(pat_root), .tgt_root(tgt_root),
      .pat_rd_id(pat_rd_id), .pat_rd_node(pat_rd_node),
      .tgt_rd_id(tgt_rd_id), .tgt_rd_node(tgt_rd_node),
      .busy(busy), .done(done), .result(result), .bind_pop(bind_pop),
      .bind_valid(bind_valid), .bind_data(bind_data), .bind_level(bind_level));

   function automatic int mk(input int tag, input int sym, input int ar, input int c0, input int c1);
      mem[nxt] = {c1[7:0], c0[7:0], sym[7:0], ar[1:0], tag[1:0]};
      nxt++;
      return nxt - 1;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run(input int p, input int t, output int cyc);
      @(negedge clk);
      pat_root = p[7:0]; tgt_root = t[7:0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0; cyc = 1;
      while (!done && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic pop_one(output int sym, output int id);
      sym = int'(bind_data[15:8]);
      id  = int'(bind_data[7:0]);
      bind_pop = 1'b1;
      @(negedge clk);
      bind_pop = 1'b0;
   endtask

   int ca, cb, cc, xv, yv, zv;

   task automatic t_reset;
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 level", int'(bind_level), 0);
      chk("R1 valid", int'(bind_valid), 0);
   endtask

   task automatic t_var_bind;
      int p, t, cyc, s, i, g;
      p = mk(F_TAG, 8'h12, 1, xv, 0);
      t = mk(F_TAG, 8'h12, 1, ca, 0);
      run(p, t, cyc);
      chk("R3 f(X)~f(a) result", int'(result), 0);
      chk("R5 match latency 2 nodes", cyc, 4);
      chk("R6 level one binding", int'(bind_level), 1);
      pop_one(s, i);
      chk("R3 bound symbol", s, 8'h40);
      chk("R3 bound id", i, ca);
      g = mk(F_TAG, 8'h11, 1, ca, 0);
      run(xv, g, cyc);
      chk("R3 X~g(a) result", int'(result), 0);
      chk("R5 match latency 1 node", cyc, 3);
      pop_one(s, i);
      chk("R3 non-leaf subterm id", i, g);
   endtask

   task automatic t_shape;
      int cyc, p, t, v;
      p = mk(F_TAG, 8'h10, 2, ca, cb);
      t = mk(F_TAG, 8'h10, 2, cb, ca);
      run(p, t, cyc);
      chk("R2 ordered children", int'(result), 1);
      p = mk(F_TAG, 8'h10, 1, ca, 0);
      t = mk(F_TAG, 8'h10, 2, ca, ca);
      run(p, t, cyc);
      chk("R2 arity differs", int'(result), 1);
      chk("R5 root mismatch fails after 2 edges", cyc, 2);
      run(ca, cb, cyc);
      chk("R2 symbol differs", int'(result), 1);
      v = mk(V_TAG, 1, 0, 0, 0);
      run(ca, v, cyc);
      chk("R2 tag differs", int'(result), 1);
      run(p, p, cyc);
      chk("R2 equal function nodes match", int'(result), 0);
   endtask

   task automatic t_fail_fast;
      int cyc, p, t;
      p = mk(F_TAG, 8'h10, 2, cb, yv);
      t = mk(F_TAG, 8'h10, 2, ca, cc);
      run(p, t, cyc);
      chk("R5 first child mismatch result", int'(result), 1);
      chk("R5 stops at first mismatch", cyc, 3);
      chk("R10 no bindings after fail", int'(bind_level), 0);
   endtask

   task automatic t_repeat;
      int cyc, p, t, g, s, i;
      p = mk(F_TAG, 8'h10, 2, xv, xv);
      t = mk(F_TAG, 8'h10, 2, ca, ca);
      run(p, t, cyc);
      chk("R4 f(X,X)~f(a,a)", int'(result), 0);
      chk("R4 single binding", int'(bind_level), 1);
      t = mk(F_TAG, 8'h10, 2, ca, cb);
      run(p, t, cyc);
      chk("R4 f(X,X)~f(a,b)", int'(result), 1);
      chk("R10 level after fail", int'(bind_level), 0);
      chk("R10 valid after fail", int'(bind_valid), 0);
      g = mk(F_TAG, 8'h11, 1, ca, 0);
      t = mk(F_TAG, 8'h10, 2, g, g);
      run(p, t, cyc);
      chk("R4 shared subterm", int'(result), 0);
      pop_one(s, i);
      chk("R4 capture id", i, g);
   endtask

   task automatic t_order;
      int cyc, p, t, q, r, s, i;
      q = mk(F_TAG, 8'h10, 2, xv, zv);
      p = mk(F_TAG, 8'h10, 2, yv, q);
      r = mk(F_TAG, 8'h10, 2, cb, cc);
      t = mk(F_TAG, 8'h10, 2, ca, r);
      run(p, t, cyc);
      chk("R6 result", int'(result), 0);
      chk("R6 level 3", int'(bind_level), 3);
      pop_one(s, i);
      chk("R6 first Y", s, 8'h41);
      chk("R6 Y=a", i, ca);
      chk("R6 level 2", int'(bind_level), 2);
      pop_one(s, i);
      chk("R6 second X", s, 8'h40);
      chk("R6 X=b", i, cb);
      pop_one(s, i);
      chk("R6 third Z", s, 8'h42);
      chk("R6 Z=c", i, cc);
      chk("R6 drained", int'(bind_level), 0);
      chk("R6 valid low", int'(bind_valid), 0);
   endtask

   task automatic t_clear;
      int cyc, p, t, s, i;
      p = mk(F_TAG, 8'h12, 1, xv, 0);
      t = mk(F_TAG, 8'h12, 1, cb, 0);
      run(p, t, cyc);
      run(p, t, cyc);
      chk("R7 no leftover bindings", int'(bind_level), 1);
      pop_one(s, i);
      chk("R7 fresh capture", i, cb);
   endtask

   task automatic t_overflow(input int nvars, input int exp_res);
      int cyc, p, t, v;
      p = mk(V_TAG, 8'h80 + nvars - 1, 0, 0, 0);
      t = cc;
      for (int k = nvars - 2; k >= 0; k--) begin
         v = mk(V_TAG, 8'h80 + k, 0, 0, 0);
         p = mk(F_TAG, 8'h11, 2, v, p);
         t = mk(F_TAG, 8'h11, 2, ca, t);
      end
      run(p, t, cyc);
      chk($sformatf("R8 %0d distinct variables", nvars), int'(result), exp_res);
      chk("R8 level", int'(bind_level), (exp_res == 0) ? nvars : 0);
   endtask

   task automatic t_depth(input int levels, input int exp_res);
      int cyc, p;
      p = cc;
      for (int k = 0; k < levels; k++) p = mk(F_TAG, 8'h10, 2, p, cc);
      run(p, p, cyc);
      chk($sformatf("R9 chain of %0d", levels), int'(result), exp_res);
      if (exp_res != 0) chk("R10 level after depth error", int'(bind_level), 0);
   endtask

   task automatic t_busy_start;
      int cyc, p, t;
      p = mk(F_TAG, 8'h10, 2, xv, xv);
      t = mk(F_TAG, 8'h10, 2, ca, cb);
      @(negedge clk);
      pat_root = p[7:0]; tgt_root = t[7:0]; start = 1'b1;
      @(negedge clk);
      pat_root = ca[7:0]; tgt_root = ca[7:0];
      cyc = 1;
      repeat (2) begin @(negedge clk); cyc++; end
      start = 1'b0;
      while (!done && cyc < 200) begin @(negedge clk); cyc++; end
      chk("R11 start while busy ignored", int'(result), 1);
      chk("R11 original walk latency", cyc, 4);
   endtask

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = '0;
      ca = mk(C_TAG, 1, 0, 0, 0);
      cb = mk(C_TAG, 2, 0, 0, 0);
      cc = mk(C_TAG, 3, 0, 0, 0);
      xv = mk(V_TAG, 8'h40, 0, 0, 0);
      yv = mk(V_TAG, 8'h41, 0, 0, 0);
      zv = mk(V_TAG, 8'h42, 0, 0, 0);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_var_bind();
      t_shape();
      t_fail_fast();
      t_repeat();
      t_order();
      t_clear();
      t_overflow(16, 0);
      t_overflow(17, 2);
      t_depth(15, 0);
      t_depth(16, 3);
      t_busy_start();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule